// File: doc/BRIEF.md
# Register-Pointer I2C Slave Front End

This block is the serial side of a small I/O expander. It runs on the system clock. It oversamples the SCL and SDA bus lines and detects start, repeated start and stop conditions. It answers one fixed 7-bit address. The block keeps a command pointer that selects one of four 8-bit registers in a neighbouring register bank. Writes reach that bank as single-cycle strobes. Reads take the selected register's value from a combinational read port. SDA is only ever pulled low, through an output-enable.

The pointer is set by the first byte after the address in a write transfer. It then stays in place for every later byte, across repeated starts and across separate transactions. There is no auto-increment, so a burst of data bytes all land in the same register. A burst of read bytes all come from the same register, and each read byte is reloaded as it is acknowledged.

Top module: `i2c_regport_slave`

## Requirements
- R1: After reset, `sda_oe` is 0, `reg_ptr` is 0 and no write strobe has been issued. A reset during a transaction returns the pointer to 0.
- R2: An address byte whose upper seven bits equal 7'h41 is acknowledged: `sda_oe` holds SDA low for the whole high phase of the ninth clock. Bit 0 of that byte is the direction, where 1 means read and 0 means write.
- R3: An address byte that does not match is not acknowledged. The slave keeps SDA released and issues no strobe until the next start or stop.
- R4: In a write transfer, the first byte after the address is acknowledged and loads its two low bits into `reg_ptr` (0 input, 1 output, 2 polarity, 3 configuration). It issues no write strobe.
- R5: Every later byte of the write transfer is acknowledged. Each one produces exactly one single-cycle `reg_wr_en` pulse, with `reg_wr_sel` equal to the pointer and `reg_wr_data` equal to the byte.
- R6: The pointer is kept across stops, repeated starts and new transactions. A read that carries no command byte returns the register selected earlier.
- R7: In a read transfer, the selected register's byte is sent MSB first. Another byte follows each master ACK. After a master NACK, SDA stays released.
- R8: The byte to be sent is captured from `reg_rd_data` on the rising SCL edge of the acknowledge clock that comes before it. A change in read data after that edge only shows in the next byte.
- R9: A stop in the middle of a data byte aborts the transfer without a write strobe.
- R10: SDA, as driven by the slave, does not change while SCL is high, except at start and stop conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| reg_ptr | output | PTR_W | Current register pointer, which also selects the read data |
| reg_rd_data | input | 8 | Read data of the register selected by `reg_ptr` |
| reg_wr_en | output | 1 | Single-cycle write strobe |
| reg_wr_sel | output | PTR_W | Register targeted by the strobe |
| reg_wr_data | output | 8 | Byte carried by the strobe |

## Verification
The bench builds the block with its defaults: address 7'h41, two synchronizer stages and a three-sample agreement filter. It drives the bus at ten system clocks per quarter bit, so the five-cycle input latency is well inside each SCL phase. That leaves the protocol state machine as the thing under test: it makes pointer retention across repeated starts, multi-byte bursts, read-data refresh at each acknowledge, and aborts on a stop part-way through a byte all reachable with a few dozen bus bytes.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
   localparam int BYTE_W = 8;
   localparam int CNT_W  = $clog2(BYTE_W + 1);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK,
      ST_SKIP
   } bus_state_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $error("FILT_LEN must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
   end

   if (FILT_LEN == 1) begin : g_nofilt
      assign line_o = sync_q[SYNC_STAGES-1];
   end else begin : g_filt
      logic [FILT_LEN-1:0] win_q;
      logic                lvl_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            win_q <= '1;
            lvl_q <= 1'b1;
         end else begin
            win_q <= {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
            if (&win_q)       lvl_q <= 1'b1;
            else if (~|win_q) lvl_q <= 1'b0;
         end
      end
      assign line_o = lvl_q;
   end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_lvl,
   input  logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_lvl;
         sda_q <= sda_lvl;
      end
   end

   assign scl_rise  = scl_lvl & ~scl_q;
   assign scl_fall  = ~scl_lvl & scl_q;
   assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
   assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
   import i2c_regport_pkg::*;
#(
   parameter logic [6:0] SLAVE_ADDR = 7'h41,
   parameter int         PTR_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_lvl,
   input  logic              sda_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              sda_oe,
   output logic [PTR_W-1:0]  ptr,
   output logic              wr_en,
   output logic [PTR_W-1:0]  wr_sel,
   output logic [BYTE_W-1:0] wr_data
);
   if (PTR_W < 1 || PTR_W > BYTE_W) begin : g_bad_ptr
      $error("PTR_W must lie in 1..8");
   end

   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

   bus_state_e        state;
   logic [CNT_W-1:0]  bitcnt;
   logic [BYTE_W-1:0] rx_sh, tx_sh;
   logic              is_read, cmd_next, mack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bitcnt   <= '0;
         rx_sh    <= '0;
         tx_sh    <= '0;
         is_read  <= 1'b0;
         cmd_next <= 1'b0;
         mack     <= 1'b0;
         sda_oe   <= 1'b0;
         ptr      <= '0;
         wr_en    <= 1'b0;
         wr_sel   <= '0;
         wr_data  <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR, ST_WR: begin
                  if (scl_rise) begin
                     rx_sh  <= {rx_sh[BYTE_W-2:0], sda_lvl};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall && bitcnt == LAST_BIT) begin
                     if (state == ST_ADDR) begin
                        if (rx_sh[BYTE_W-1:1] == SLAVE_ADDR) begin
                           state   <= ST_ADDR_ACK;
                           is_read <= rx_sh[0];
                           sda_oe  <= 1'b1;
                        end else begin
                           state <= ST_SKIP;
                        end
                     end else begin
                        if (cmd_next) begin
                           ptr      <= rx_sh[PTR_W-1:0];
                           cmd_next <= 1'b0;
                        end else begin
                           wr_en   <= 1'b1;
                           wr_sel  <= ptr;
                           wr_data <= rx_sh;
                        end
                        state  <= ST_WR_ACK;
                        sda_oe <= 1'b1;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_rise) tx_sh <= rd_data;
                  else if (scl_fall) begin
                     bitcnt <= '0;
                     if (is_read) begin
                        state  <= ST_RD;
                        sda_oe <= ~tx_sh[BYTE_W-1];
                     end else begin
                        state    <= ST_WR;
                        cmd_next <= 1'b1;
                        sda_oe   <= 1'b0;
                     end
                  end
               end
               ST_WR_ACK: begin
                  if (scl_fall) begin
                     state  <= ST_WR;
                     bitcnt <= '0;
                     sda_oe <= 1'b0;
                  end
               end
               ST_RD: begin
                  if (scl_rise) bitcnt <= bitcnt + 1'b1;
                  else if (scl_fall) begin
                     if (bitcnt == LAST_BIT) begin
                        state  <= ST_RD_ACK;
                        sda_oe <= 1'b0;
                     end else begin
                        tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~tx_sh[BYTE_W-2];
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) begin
                     mack  <= ~sda_lvl;
                     tx_sh <= rd_data;
                  end else if (scl_fall) begin
                     if (mack) begin
                        state  <= ST_RD;
                        bitcnt <= '0;
                        sda_oe <= ~tx_sh[BYTE_W-1];
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R2
   addr_ack_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADDR_ACK) |-> (rx_sh[BYTE_W-1:1] == SLAVE_ADDR));
   // R3
   skip_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> !sda_oe);
   // R5
   wr_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);
   // R9
   wr_only_at_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (state == ST_WR_ACK));
   // R10
   sda_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe));
endmodule

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave #(
   parameter logic [6:0] SLAVE_ADDR  = 7'h41,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_LEN    = 3,
   parameter int         PTR_W       = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe,
   output logic [PTR_W-1:0] reg_ptr,
   input  logic [7:0]       reg_rd_data,
   output logic             reg_wr_en,
   output logic [PTR_W-1:0] reg_wr_sel,
   output logic [7:0]       reg_wr_data
);
   localparam int N_LINES = 2;

   logic [N_LINES-1:0] raw_lines, clean_lines;
   logic scl_rise, scl_fall, start_det, stop_det;

   assign raw_lines = {scl_i, sda_i};

   for (genvar g = 0; g < N_LINES; g++) begin : g_line
      i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_i (raw_lines[g]),
         .line_o (clean_lines[g])
      );
   end

   i2c_cond_detect u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_lvl   (clean_lines[1]),
      .sda_lvl   (clean_lines[0]),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_byte_engine #(.SLAVE_ADDR(SLAVE_ADDR), .PTR_W(PTR_W)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_lvl   (clean_lines[1]),
      .sda_lvl   (clean_lines[0]),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .rd_data   (reg_rd_data),
      .sda_oe    (sda_oe),
      .ptr       (reg_ptr),
      .wr_en     (reg_wr_en),
      .wr_sel    (reg_wr_sel),
      .wr_data   (reg_wr_data)
   );
endmodule

// File: tb/i2c_regport_slave_tb.sv
module i2c_regport_slave_tb;
   localparam int Q = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic sda_oe, reg_wr_en;
   logic [1:0] reg_ptr, reg_wr_sel;
   logic [7:0] reg_rd_data, reg_wr_data;
   logic [7:0] bank [4];
   logic [7:0] in_pins = 8'h00;
   wire sda_line = sda_m & ~sda_oe;

   int n_vec = 0, n_bad = 0, n_wr = 0;
   logic [1:0] last_sel;
   logic [7:0] last_data;
   logic watch_oe = 1'b0, oe_seen = 1'b0, done = 1'b0;

   always #2 clk = ~clk;

   i2c_regport_slave u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .reg_ptr(reg_ptr), .reg_rd_data(reg_rd_data),
      .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data)
   );

   assign reg_rd_data = (reg_ptr == 2'd0) ? in_pins : bank[reg_ptr];

   always @(posedge clk) begin
      if (!rst_n) begin
         bank[0] <= 8'h00; bank[1] <= 8'hFF; bank[2] <= 8'h00; bank[3] <= 8'hFF;
      end else if (reg_wr_en) begin
         n_wr      <= n_wr + 1;
         last_sel  <= reg_wr_sel;
         last_data <= reg_wr_data;
         if (reg_wr_sel != 2'd0) bank[reg_wr_sel] <= reg_wr_data;
      end
      if (watch_oe && sda_oe) oe_seen <= 1'b1;
   end

   // cmd[25:24] wdata[23:16] pins[15:8] expected[7:0]
   localparam logic [25:0] VECS [6] = '{
      {2'd1, 8'hA5, 8'h00, 8'hA5},
      {2'd3, 8'h0F, 8'h00, 8'h0F},
      {2'd2, 8'h3C, 8'h00, 8'h3C},
      {2'd0, 8'hFF, 8'h5A, 8'h5A},
      {2'd1, 8'h00, 8'h00, 8'h00},
      {2'd0, 8'h12, 8'hC3, 8'hC3}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wq; repeat (Q) @(negedge clk); endtask

   task automatic bus_start;
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
   endtask

   task automatic write_byte(input logic [7:0] d, output logic acked);
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
      acked = ~sda_line;
      wq(); scl_m = 1'b0; wq();
   endtask

   task automatic read_byte(input logic give_ack, output logic [7:0] d);
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
         d[i] = sda_line;
         wq(); scl_m = 1'b0; wq();
      end
      send_bit(~give_ack);
   endtask

   initial begin
      repeat (Q * 150000 / Q) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic a;
      logic [7:0] d;
      int w0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      wq();
      // R1 reset state
      chk("R1 oe", sda_oe, 0);
      chk("R1 ptr", reg_ptr, 0);
      chk("R1 strobes", n_wr, 0);

      // vector table: write cmd+data, repeated start, read back
      foreach (VECS[k]) begin
         in_pins = VECS[k][15:8];
         w0 = n_wr;
         bus_start();
         write_byte(8'h82, a); chk("R2 addr ack", a, 1);
         write_byte({6'd0, VECS[k][25:24]}, a); chk("R4 cmd ack", a, 1);
         chk("R4 ptr", reg_ptr, VECS[k][25:24]);
         chk("R4 no strobe", n_wr, w0);
         write_byte(VECS[k][23:16], a); chk("R5 data ack", a, 1);
         chk("R5 strobe", {n_wr, 6'd0, last_sel, last_data},
             {w0 + 1, 6'd0, VECS[k][25:24], VECS[k][23:16]});
         bus_start();
         write_byte(8'h83, a); chk("R6 addr after repeated start", a, 1);
         read_byte(1'b0, d); chk("R7 read value", d, VECS[k][7:0]);
         bus_stop();
      end

      // R3 address mismatch
      w0 = n_wr; oe_seen = 1'b0; watch_oe = 1'b1;
      bus_start();
      write_byte(8'h84, a); chk("R3 mismatch nack", a, 0);
      write_byte(8'h01, a); chk("R3 ignored byte nack", a, 0);
      write_byte(8'h77, a);
      watch_oe = 1'b0;
      chk("R3 sda never driven", oe_seen, 0);
      chk("R3 no strobe", n_wr, w0);
      bus_stop();

      // R5 burst to one register, no auto-increment
      w0 = n_wr;
      bus_start();
      write_byte(8'h82, a); write_byte(8'h01, a);
      write_byte(8'h11, a); write_byte(8'h22, a); write_byte(8'h33, a);
      bus_stop();
      chk("R5 burst count", n_wr, w0 + 3);
      chk("R5 burst sel", last_sel, 1);
      chk("R5 burst bank out", bank[1], 8'h33);
      chk("R5 burst bank cfg untouched", bank[3], 8'h0F);

      // R6 pointer kept across a fresh transaction
      bus_start();
      write_byte(8'h83, a);
      read_byte(1'b0, d); chk("R6 read without cmd", d, 8'h33);
      bus_stop();

      // R8 fresh input sample per byte, R7 multi-byte read and NACK release
      bus_start(); write_byte(8'h82, a); write_byte(8'h00, a); bus_stop();
      in_pins = 8'h81;
      bus_start();
      write_byte(8'h83, a);
      in_pins = 8'h7E;
      read_byte(1'b1, d); chk("R8 first byte", d, 8'h81);
      in_pins = 8'hC5;
      read_byte(1'b1, d); chk("R8 second byte", d, 8'h7E);
      read_byte(1'b0, d); chk("R7 third byte", d, 8'hC5);
      wq();
      chk("R7 released after nack", sda_oe, 0);
      bus_stop();

      // R9 stop mid-byte
      bus_start(); write_byte(8'h82, a); write_byte(8'h03, a);
      w0 = n_wr;
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
      bus_stop();
      chk("R9 no strobe", n_wr, w0);
      bus_start(); write_byte(8'h83, a); read_byte(1'b0, d); bus_stop();
      chk("R9 cfg kept", d, 8'h0F);

      // R1 reset in a transaction clears the pointer
      bus_start(); write_byte(8'h82, a); write_byte(8'h02, a);
      rst_n = 1'b0; wq(); rst_n = 1'b1; wq();
      chk("R1 ptr after reset", reg_ptr, 0);
      chk("R1 oe after reset", sda_oe, 0);
      bus_stop();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule